// File: doc/BRIEF.md
# Dual 8-bit PWM/Interval Timer

This block holds two 8-bit timer channels. Each channel runs in one of two modes. In interval mode it counts ticks from zero up to a programmed limit, then wraps, flips a square-wave output and raises a sticky interrupt flag. In PWM mode it counts through a fixed 256-tick frame and drives its output high while the count is below a programmed duty value. Ticks come from a per-channel prescaler that divides an instruction-cycle strobe by 1, 8, 16 or 64. Channel 1 can also take its ticks from the rising edges of channel 0's output, so the two channels chain into a longer timer.

Software reaches the block through a small register port. The port has a write strobe, a 2-bit address, write data and a combinational read bus. A limit or duty value written while a channel runs waits in a holding register and takes effect only at the next period boundary, so a running waveform never glitches. Stopping a channel clears its counter and prescaler and drives its output low.

Top module: `dual_pwm_timer`

## Requirements
- R1: After reset both outputs and both flags are 0, and every register reads back as 0.
- R2: The register layout is: address 2*n is the control register of channel n, and address 2*n+1 is its limit/duty register. Control bits are: [0] run, [1] mode (1 = PWM), [3:2] clock select, [4] chain, and [7] flag. Bits [6:5] read as 0. Written values read back.
- R3: Clock select 00, 01, 10 and 11 give one tick every 1, 8, 16 and 64 instruction strobes. No tick occurs while `inst_en` is low.
- R4: In interval mode with limit C, the output starts low at run and toggles on every (C+1)-th tick.
- R5: In interval mode the channel's flag is set on the tick that toggles the output, and it stays set.
- R6: Writing a control word with bit 7 = 1 clears the flag. Writing bit 7 = 0 leaves it unchanged.
- R7: In PWM mode the frame is 256 ticks long. The output is high exactly while the count (0 at run) is below the duty value, so a duty of 0 keeps the output low.
- R8: In PWM mode the flag is set at the end of each frame, on the tick where the count passes 255 and returns to 0.
- R9: A limit or duty written while the channel runs takes effect only at the next period boundary. A value written while the channel is stopped is used from the start.
- R10: Clearing run drives the output low at once and resets the counter and prescaler, so a restart repeats the timing of a fresh start.
- R11: With chain set, channel 1 counts one tick per rising edge of channel 0's output. The tick lands one cycle after that edge, and clock select and `inst_en` are ignored. The chain bit of channel 0 has no effect.
- R12: The two channels count and flag independently when chaining is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_en | input | 1 | Instruction-cycle strobe feeding the prescalers |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data at `bus_addr` |
| wave_o | output | 2 | Waveform output per channel |
| irq_o | output | 2 | Sticky interrupt flag per channel |

## Verification
A counter or prescaler that is not cleared on stop shows up right after restart: the first toggle arrives early, within at most one period. If the active limit were loaded at the moment of writing instead of at the boundary, a limit shrunk below the running count would make the counter run on to 255. That would delay the expected toggle by hundreds of cycles, and a change of PWM duty would show one frame early. A broken chain edge detect makes channel 1 follow its own prescaler, which misses the toggle expected seven cycles after channel 0 starts.

// File: rtl/dpt_pkg.sv
`timescale 1ns/1ps
package dpt_pkg;

    // Tick source division of the instruction-cycle strobe
    typedef enum logic [1:0] {
        CLK_DIV1  = 2'b00,
        CLK_DIV8  = 2'b01,
        CLK_DIV16 = 2'b10,
        CLK_DIV64 = 2'b11
    } clk_sel_e;

    // Control word stored per channel (flag kept separately)
    typedef struct packed {
        logic     chain;
        clk_sel_e sel;
        logic     pwm;
        logic     run;
    } ctrl_t;

    localparam int FLAG_BIT = 7;

    // Last prescaler count before a tick
    function automatic int unsigned div_last(input clk_sel_e s);
        case (s)
            CLK_DIV1:  return 0;
            CLK_DIV8:  return 7;
            CLK_DIV16: return 15;
            default:   return 63;
        endcase
    endfunction

endpackage

// File: rtl/dpt_prescaler.sv
`timescale 1ns/1ps
module dpt_prescaler
    import dpt_pkg::*;
#(
    parameter int PS_W = 6
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     inst_en,
    input  clk_sel_e sel,
    output logic     tick
);

    logic [PS_W-1:0] pcnt;
    logic [PS_W-1:0] last;

    assign last = PS_W'(div_last(sel));
    // >= keeps a select change mid-count from running to the wrap
    assign tick = run && inst_en && (pcnt >= last);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt <= '0;
        end else if (inst_en) begin
            pcnt <= (pcnt >= last) ? '0 : pcnt + 1'b1;
        end
    end

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick && (last != '0) |=> !tick || !$stable(sel));

    // R3
    presc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        run && !inst_en |=> $stable(pcnt));

endmodule

// File: rtl/dpt_core.sv
`timescale 1ns/1ps
module dpt_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         pwm,
    input  logic         tick,
    input  logic [W-1:0] lim_in,
    output logic         wave,
    output logic         period_end
);

    localparam logic [W-1:0] FRAME_TOP = '1;

    logic [W-1:0] cnt;
    logic [W-1:0] lim_act;
    logic         tog;

    assign period_end = run && tick && (pwm ? (cnt == FRAME_TOP) : (cnt == lim_act));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            lim_act <= '0;
            tog     <= 1'b0;
        end else if (!run) begin
            cnt     <= '0;
            tog     <= 1'b0;
            lim_act <= lim_in;
        end else if (period_end) begin
            cnt     <= '0;
            lim_act <= lim_in;
            if (!pwm) tog <= ~tog;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign wave = run && (pwm ? (cnt < lim_act) : tog);

    // R10
    stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0) && !tog);

    // R4
    toggle_chk: assert property (@(posedge clk) disable iff (rst)
        period_end && !pwm |=> tog != $past(tog));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        run && !period_end |=> $stable(lim_act));

endmodule

// File: rtl/dpt_regs.sv
`timescale 1ns/1ps
module dpt_regs
    import dpt_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [CNT_W-1:0]          wdata,
    input  logic [NCH-1:0]            period_end,
    output ctrl_t [NCH-1:0]           ctrl,
    output logic [NCH-1:0][CNT_W-1:0] lim,
    output logic [NCH-1:0]            flag,
    output logic [CNT_W-1:0]          rdata
);

    localparam int CTRL_BITS = $bits(ctrl_t);
    localparam int PAD_BITS  = FLAG_BIT - CTRL_BITS;

    logic unused_wbits;
    assign unused_wbits = ^wdata[FLAG_BIT-1:CTRL_BITS];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2 * i);
        localparam logic [ADDR_W-1:0] A_LIM  = ADDR_W'(2 * i + 1);

        ctrl_t            ctrl_r;
        logic [CNT_W-1:0] lim_r;
        logic             flag_r;
        logic             hit_ctrl;
        logic             hit_lim;

        assign hit_ctrl = wr && (addr == A_CTRL);
        assign hit_lim  = wr && (addr == A_LIM);

        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_r <= '0;
                lim_r  <= '0;
                flag_r <= 1'b0;
            end else begin
                if (hit_ctrl) ctrl_r <= ctrl_t'(wdata[CTRL_BITS-1:0]);
                if (hit_lim)  lim_r  <= wdata;
                if (period_end[i])                   flag_r <= 1'b1;
                else if (hit_ctrl && wdata[FLAG_BIT]) flag_r <= 1'b0;
            end
        end

        assign ctrl[i] = ctrl_r;
        assign lim[i]  = lim_r;
        assign flag[i] = flag_r;

        // R5
        flag_set_chk: assert property (@(posedge clk) disable iff (rst)
            period_end[i] |=> flag[i]);

        // R6
        flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
            hit_ctrl && wdata[FLAG_BIT] && !period_end[i] |=> !flag[i]);
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (addr == ADDR_W'(2 * i))
                rdata = CNT_W'({flag[i], {PAD_BITS{1'b0}}, ctrl[i]});
            else if (addr == ADDR_W'(2 * i + 1))
                rdata = lim[i];
        end
    end

endmodule

// File: rtl/dual_pwm_timer.sv
`timescale 1ns/1ps
module dual_pwm_timer
    import dpt_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int CNT_W  = 8,
    parameter int PS_W   = 6,
    parameter int ADDR_W = $clog2(2 * NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inst_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NCH-1:0]    wave_o,
    output logic [NCH-1:0]    irq_o
);

    ctrl_t [NCH-1:0]           ctrl;
    logic [NCH-1:0][CNT_W-1:0] lim;
    logic [NCH-1:0]            flag;
    logic [NCH-1:0]            period_end;
    logic [NCH-1:0]            wave;
    logic [NCH-1:0]            ps_tick;
    logic [NCH-1:0]            core_tick;

    dpt_regs #(
        .NCH    (NCH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .period_end (period_end),
        .ctrl       (ctrl),
        .lim        (lim),
        .flag       (flag),
        .rdata      (bus_rdata)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dpt_prescaler #(.PS_W(PS_W)) u_ps (
            .clk     (clk),
            .rst     (rst),
            .run     (ctrl[i].run),
            .inst_en (inst_en),
            .sel     (ctrl[i].sel),
            .tick    (ps_tick[i])
        );

        if (i == 0) begin : g_head
            assign core_tick[i] = ps_tick[i];
        end else begin : g_chain
            logic src_q;
            logic src_rise;

            always_ff @(posedge clk) begin
                if (rst) src_q <= 1'b0;
                else     src_q <= wave[i-1];
            end

            assign src_rise     = wave[i-1] && !src_q;
            assign core_tick[i] = ctrl[i].chain ? src_rise : ps_tick[i];

            // R11
            chain_tick_chk: assert property (@(posedge clk) disable iff (rst)
                ctrl[i].chain && core_tick[i] |-> $rose(wave[i-1]));
        end

        dpt_core #(.W(CNT_W)) u_core (
            .clk        (clk),
            .rst        (rst),
            .run        (ctrl[i].run),
            .pwm        (ctrl[i].pwm),
            .tick       (core_tick[i]),
            .lim_in     (lim[i]),
            .wave       (wave[i]),
            .period_end (period_end[i])
        );

        // R10
        stop_low_chk: assert property (@(posedge clk) disable iff (rst)
            !ctrl[i].run |-> !wave_o[i]);
    end

    assign wave_o = wave;
    assign irq_o  = flag;

endmodule

// File: tb/test_dual_pwm_timer.sv
`timescale 1ns/1ps
module test_dual_pwm_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       inst_en = 1'b1;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] wave_o;
    logic [1:0] irq_o;

    dual_pwm_timer i_dual_pwm_timer (
        .clk       (clk),
        .rst       (rst),
        .inst_en   (inst_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wave_o    (wave_o),
        .irq_o     (irq_o)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        int    ch;
        logic  wave;
        logic  irq;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;

    task automatic push(input int at, input int ch, input logic w, input logic i, input string tag);
        exp_t e;
        e.at = at; e.ch = ch; e.wave = w; e.irq = i; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: pops expected items in their due cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (e.at != cyc || wave_o[e.ch] !== e.wave || irq_o[e.ch] !== e.irq) begin
                fails++;
                $display("FAIL %s ch%0d cyc=%0d due=%0d: wave=%b irq=%b expected wave=%b irq=%b",
                         e.tag, e.ch, cyc, e.at, wave_o[e.ch], irq_o[e.ch], e.wave, e.irq);
            end
        end
    end

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic stop_clear(input int ch);
        wr(2'(2 * ch), 8'h00);
        wr(2'(2 * ch), 8'h80);
    endtask

    initial begin
        int k, k0, k1, m;
        logic [7:0] d;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 wave", {6'b0, wave_o}, 8'h00);
        chk("R1 irq",  {6'b0, irq_o},  8'h00);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 reg", d, 8'h00);
        end

        // R2 register readback
        wr(2'd1, 8'h5A);
        wr(2'd0, 8'h1C);
        rd(2'd1, d); chk("R2 limit", d, 8'h5A);
        rd(2'd0, d); chk("R2 ctrl",  d, 8'h1C);
        chk("R2 no run", {6'b0, wave_o}, 8'h00);
        wr(2'd0, 8'h00);

        // R4/R5 interval, div 1, limit 3
        wr(2'd1, 8'd3);
        wr(2'd0, 8'h01);
        k = cyc;
        push(k + 3, 0, 1'b0, 1'b0, "R4");
        push(k + 4, 0, 1'b1, 1'b1, "R5");
        push(k + 7, 0, 1'b1, 1'b1, "R4");
        push(k + 8, 0, 1'b0, 1'b1, "R5");
        drain();
        wr(2'd0, 8'h00);
        chk("R10 stop low", {7'b0, wave_o[0]}, 8'h00);
        chk("R5 sticky",    {7'b0, irq_o[0]},  8'h01);
        wr(2'd0, 8'h00);
        chk("R6 write0 keeps", {7'b0, irq_o[0]}, 8'h01);
        wr(2'd0, 8'h80);
        chk("R6 write1 clears", {7'b0, irq_o[0]}, 8'h00);
        rd(2'd0, d); chk("R6 readback", d, 8'h00);

        // R10 restart timing; R11 chain bit on channel 0 is ignored
        wr(2'd0, 8'h11);
        k = cyc;
        push(k + 3, 0, 1'b0, 1'b0, "R11");
        push(k + 4, 0, 1'b1, 1'b1, "R10");
        drain();
        stop_clear(0);

        // R3 prescaler divide by 8, limit 2
        wr(2'd1, 8'd2);
        wr(2'd0, 8'h05);
        k = cyc;
        push(k + 23, 0, 1'b0, 1'b0, "R3");
        push(k + 24, 0, 1'b1, 1'b1, "R3");
        drain();
        stop_clear(0);

        // R3 divide by 16, limit 0
        wr(2'd1, 8'd0);
        wr(2'd0, 8'h09);
        k = cyc;
        push(k + 15, 0, 1'b0, 1'b0, "R3");
        push(k + 16, 0, 1'b1, 1'b1, "R3");
        push(k + 31, 0, 1'b1, 1'b1, "R3");
        push(k + 32, 0, 1'b0, 1'b1, "R3");
        drain();
        stop_clear(0);

        // R3 divide by 64
        wr(2'd0, 8'h0D);
        k = cyc;
        push(k + 63, 0, 1'b0, 1'b0, "R3");
        push(k + 64, 0, 1'b1, 1'b1, "R3");
        drain();
        stop_clear(0);

        // R3 no ticks without the strobe
        inst_en = 1'b0;
        wr(2'd1, 8'd3);
        wr(2'd0, 8'h01);
        k = cyc;
        push(k + 20, 0, 1'b0, 1'b0, "R3");
        drain();
        @(negedge clk);
        inst_en = 1'b1;
        m = cyc;
        push(m + 3, 0, 1'b0, 1'b0, "R3");
        push(m + 4, 0, 1'b1, 1'b1, "R3");
        drain();
        stop_clear(0);

        // R7/R8/R9 PWM on channel 1, duty 0x40 then 0xC0
        wr(2'd3, 8'h40);
        wr(2'd2, 8'h03);
        k = cyc;
        push(k + 8'h3F, 1, 1'b1, 1'b0, "R7");
        push(k + 8'h40, 1, 1'b0, 1'b0, "R7");
        drain();
        wr(2'd3, 8'hC0);
        rd(2'd3, d); chk("R2 duty", d, 8'hC0);
        rd(2'd2, d); chk("R2 ctrl ch1", d, 8'h03);
        push(k + 8'h80,     1, 1'b0, 1'b0, "R9");
        push(k + 255,       1, 1'b0, 1'b0, "R8");
        push(k + 256,       1, 1'b1, 1'b1, "R8");
        push(k + 256 + 191, 1, 1'b1, 1'b1, "R9");
        push(k + 256 + 192, 1, 1'b0, 1'b1, "R9");
        drain();
        stop_clear(1);
        chk("R10 pwm stop", {6'b0, wave_o}, 8'h00);

        // R7 duty 0 stays low
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h03);
        k = cyc;
        push(k + 1,   1, 1'b0, 1'b0, "R7");
        push(k + 200, 1, 1'b0, 1'b0, "R7");
        drain();
        stop_clear(1);

        // R11 chaining: channel 1 counts channel 0 rising edges
        wr(2'd3, 8'd1);
        wr(2'd2, 8'h1D);
        wr(2'd1, 8'd1);
        wr(2'd0, 8'h01);
        k = cyc;
        push(k + 2,  0, 1'b1, 1'b1, "R11");
        push(k + 6,  1, 1'b0, 1'b0, "R11");
        push(k + 7,  1, 1'b1, 1'b1, "R11");
        push(k + 14, 1, 1'b1, 1'b1, "R11");
        push(k + 15, 1, 1'b0, 1'b1, "R11");
        drain();
        stop_clear(0);
        stop_clear(1);

        // R12 independent channels; R9 interval limit change while running
        wr(2'd3, 8'd4);
        wr(2'd1, 8'd9);
        wr(2'd2, 8'h01);
        k1 = cyc;
        wr(2'd0, 8'h01);
        k0 = cyc;
        push(k1 + 4,  1, 1'b0, 1'b0, "R12");
        push(k1 + 5,  1, 1'b1, 1'b1, "R12");
        push(k1 + 9,  1, 1'b1, 1'b1, "R12");
        push(k1 + 10, 1, 1'b0, 1'b1, "R12");
        push(k0 + 9,  0, 1'b0, 1'b0, "R9");
        push(k0 + 10, 0, 1'b1, 1'b1, "R9");
        push(k0 + 12, 0, 1'b1, 1'b1, "R9");
        push(k0 + 13, 0, 1'b0, 1'b1, "R9");
        wr(2'd1, 8'd2);
        drain();
        stop_clear(0);
        stop_clear(1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, pending=%0d expected 0", q.size());
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule